// File: doc/BRIEF.md
# E3 Far-End Error Event Monitor

This block watches the remote-error indication carried in every received G.832 E3 frame. An upstream framer hands it a one-cycle frame strobe together with the maintenance-and-adaptation byte pulled from that frame's overhead. The block reads a single flag from the byte. When the flag shows that the remote terminal saw an errored EM byte, the block counts the frame and sets a sticky event status bit.

Software reaches the block through a byte-wide read port with read-clear semantics. One address returns a status byte that holds the event bit. Two further addresses return the upper and lower halves of a 16-bit event count. A read of the upper half captures the whole count into a holding register and restarts the live counter, so that the two halves read back always belong to the same instant. An active-low interrupt pin is pulled low while the event status is set and the enable input is high.

Top module: `e3rei_mon`

## Requirements
- R1: The error flag is bit 6 of `ma_byte`, which is the second bit transmitted when the byte is sent MSB first. It is sampled only in cycles where `frame_vld` is 1. All other bits of `ma_byte`, and any cycle where `frame_vld` is 0, leave the count and the status unchanged.
- R2: The live counter rises by exactly one for every valid frame with the flag set, including frames that arrive back to back.
- R3: The live counter saturates at 0xFFFF and does not wrap.
- R4: A valid frame with the flag set makes the event status sticky. A status read (address 0) returns the status in bit 4, and bits 7..5 and 3..0 read as 0.
- R5: A status read clears the event status. If a flagged frame arrives in the same cycle as that read, the read returns the old value and the status stays set afterwards.
- R6: `irq_n` is 0 exactly while the event status is set and `irq_en` is 1. Clearing `irq_en` releases the pin but does not clear the status.
- R7: An upper-byte read (address 1) returns bits 15..8 of the live count and copies the full count into a holding register. The live counter then restarts at 0, or at 1 if a flagged frame arrives in the same cycle.
- R8: A lower-byte read (address 2) returns bits 7..0 of the holding register, then clears the holding register.
- R9: After reset the status, the live count and the holding register are 0, `irq_n` is 1 and `rd_data` is 0.
- R10: `rd_data` carries the result of a read in the cycle after `rd_en` is sampled high. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld | input | 1 | One-cycle strobe marking a received frame |
| ma_byte | input | 8 | Maintenance-and-adaptation byte of that frame |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 2 | Register select: 0 status, 1 count upper, 2 count lower |
| rd_data | output | 8 | Registered read result |
| irq_en | input | 1 | Enable for the interrupt pin |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A flagged frame sampled at a clock edge changes the live count and the status at that same edge. Because the pin is combinational from the status, `irq_n` moves within that cycle. Read data becomes valid one edge after `rd_en` is sampled. The bench therefore drives inputs on falling edges, and the monitor compares `rd_data` against the scoreboard queue on the falling edge after the rising edge that took the read. Pin checks are made on the falling edge that follows the stimulus, which makes the same-cycle read and event cases well defined.

// File: rtl/e3rei_pkg.sv
package e3rei_pkg;

    localparam int DATA_W   = 8;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 2;
    localparam int REI_BIT  = 6;   // second bit on the line, MSB first
    localparam int STAT_BIT = 4;   // position decoded by software

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT   = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic cnt_hi;
        logic cnt_lo;
    } rd_strobe_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/e3rei_decode.sv
module e3rei_decode
    import e3rei_pkg::*;
#(
    parameter int BYTE_W = DATA_W,
    parameter int FLAG_POS = REI_BIT
) (
    input  logic              frame_vld,
    input  logic [BYTE_W-1:0] ma_byte,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              evt,
    output rd_strobe_t        strobe
);
    always_comb begin
        evt           = frame_vld & ma_byte[FLAG_POS];
        strobe.stat   = rd_en && (rd_addr == REG_STAT);
        strobe.cnt_hi = rd_en && (rd_addr == REG_CNT_HI);
        strobe.cnt_lo = rd_en && (rd_addr == REG_CNT_LO);
    end
endmodule

// File: rtl/e3rei_counter.sv
module e3rei_counter
    import e3rei_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic         take,
    input  logic         drain,
    output logic [W-1:0] live,
    output logic [W-1:0] snap
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (take) begin
            live <= evt ? ONE : '0;
        end else if (evt) begin
            live <= sat_inc(live);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (take) begin
            snap <= live;
        end else if (drain) begin
            snap <= '0;
        end
    end
endmodule

// File: rtl/e3rei_status.sv
module e3rei_status (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    input  logic irq_en,
    output logic sticky,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= 1'b0;
        end else if (evt) begin
            sticky <= 1'b1;
        end else if (clr) begin
            sticky <= 1'b0;
        end
    end

    always_comb irq_n = ~(sticky & irq_en);
endmodule

// File: rtl/e3rei_mon.sv
module e3rei_mon
    import e3rei_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [DATA_W-1:0] ma_byte,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_en,
    output logic              irq_n
);
    localparam int HI_LSB = CNT_W - DATA_W;

    logic             evt;
    rd_strobe_t       strobe;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] snap_cnt;
    logic             sticky;

    e3rei_decode u_decode (
        .frame_vld (frame_vld),
        .ma_byte   (ma_byte),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .evt       (evt),
        .strobe    (strobe)
    );

    e3rei_counter #(.W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .take  (strobe.cnt_hi),
        .drain (strobe.cnt_lo),
        .live  (live_cnt),
        .snap  (snap_cnt)
    );

    e3rei_status u_status (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .clr    (strobe.stat),
        .irq_en (irq_en),
        .sticky (sticky),
        .irq_n  (irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (rd_addr)
                REG_STAT:   rd_data <= DATA_W'({sticky}) << STAT_BIT;
                REG_CNT_HI: rd_data <= live_cnt[HI_LSB +: DATA_W];
                REG_CNT_LO: rd_data <= snap_cnt[DATA_W-1:0];
                default:    rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/e3rei_chk.sv
module e3rei_chk
    import e3rei_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_vld,
    input logic [DATA_W-1:0] ma_byte,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_en,
    input logic              irq_n,
    input logic [CNT_W-1:0]  live_cnt,
    input logic              sticky
);
    logic flag_in, take_rd, stat_rd;
    always_comb begin
        flag_in = frame_vld && ma_byte[REI_BIT];
        take_rd = rd_en && (rd_addr == REG_CNT_HI);
        stat_rd = rd_en && (rd_addr == REG_STAT);
    end

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!flag_in && !take_rd) |=> $stable(live_cnt));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (flag_in && !take_rd && live_cnt != '1) |=> live_cnt == $past(live_cnt) + 1'b1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == '1 && !take_rd) |=> live_cnt == '1);

    assert_sticky_set_R4: assert property (@(posedge clk) disable iff (rst)
        flag_in |=> sticky);

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (rd_data & ~(8'h01 << STAT_BIT)) == 8'h00);

    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !flag_in) |=> !sticky);

    assert_pin_low_R6: assert property (@(posedge clk) disable iff (rst)
        flag_in |=> (!irq_n || !irq_en));

    assert_pin_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !sticky |-> irq_n);

    assert_take_restart_R7: assert property (@(posedge clk) disable iff (rst)
        take_rd |=> live_cnt == CNT_W'($past(flag_in)));
endmodule

bind e3rei_mon e3rei_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .ma_byte   (ma_byte),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq_en    (irq_en),
    .irq_n     (irq_n),
    .live_cnt  (live_cnt),
    .sticky    (sticky)
);

// File: tb/sim_e3rei_mon.sv
module sim_e3rei_mon;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_vld = 1'b0;
    logic [7:0] ma_byte = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq_en = 1'b1;
    logic       irq_n;

    always #4 clk = ~clk;

    e3rei_mon u0 (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .ma_byte(ma_byte),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_en(irq_en), .irq_n(irq_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    // reference state, built from the requirements
    logic [15:0] m_cnt  = '0;
    logic [15:0] m_snap = '0;
    logic        m_stat = 1'b0;

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    logic rd_q = 1'b0;
    always @(posedge clk) rd_q <= rd_en && !rst;

    always @(negedge clk) begin
        exp_t e;
        if (rd_q) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected read result %h expected none", rd_data);
            end else begin
                e = sbq.pop_front();
                if (rd_data !== e.val) begin
                    fails++;
                    $display("FAIL %s rd_data=%h expected %h", e.tag, rd_data, e.val);
                end
            end
        end
    end

    // driver: one cycle of stimulus, expected read pushed to the scoreboard
    task automatic cyc(input logic vld, input logic [7:0] ma, input logic rd,
                       input logic [1:0] a, input string tag);
        logic       ev;
        logic [7:0] ex;
        ev = vld && ma[6];
        frame_vld = vld; ma_byte = ma; rd_en = rd; rd_addr = a;
        if (rd) begin
            case (a)
                2'd0:    ex = {3'b000, m_stat, 4'b0000};
                2'd1:    ex = m_cnt[15:8];
                2'd2:    ex = m_snap[7:0];
                default: ex = 8'h00;
            endcase
            sbq.push_back('{ex, tag});
        end
        if (rd && a == 2'd0) m_stat = ev;
        else                 m_stat = m_stat | ev;
        if (rd && a == 2'd1) begin
            m_snap = m_cnt;
            m_cnt  = ev ? 16'd1 : 16'd0;
        end else if (ev && m_cnt != 16'hFFFF) begin
            m_cnt = m_cnt + 16'd1;
        end
        if (rd && a == 2'd2) m_snap = '0;
        @(negedge clk);
        frame_vld = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(1'b0, 8'h00, 1'b1, a, tag);
    endtask

    task automatic chk_irq(input logic ex, input string tag);
        checks++;
        if (irq_n !== ex) begin
            fails++;
            $display("FAIL %s irq_n=%b expected %b", tag, irq_n, ex);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state, R10 spare address
        chk_irq(1'b1, "R9");
        rd(2'd0, "R9"); rd(2'd1, "R9"); rd(2'd2, "R9");
        rd(2'd3, "R10");

        // R1: other bits set, or flag without frame strobe
        for (int i = 0; i < 3; i++) cyc(1'b1, 8'hBF, 1'b0, 2'd0, "R1");
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'h40, 1'b0, 2'd0, "R1");
        chk_irq(1'b1, "R1");
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");

        // R2 back-to-back flagged frames, R4/R5/R6 status and pin
        for (int i = 0; i < 5; i++) cyc(1'b1, 8'h40, 1'b0, 2'd0, "R2");
        chk_irq(1'b0, "R6");
        rd(2'd0, "R4");
        chk_irq(1'b1, "R5");
        rd(2'd0, "R5");
        rd(2'd1, "R7"); rd(2'd2, "R8"); rd(2'd2, "R8");

        // R6 enable masks the pin, not the status
        irq_en = 1'b0;
        cyc(1'b1, 8'hC0, 1'b0, 2'd0, "R6");
        chk_irq(1'b1, "R6");
        irq_en = 1'b1;
        #1 chk_irq(1'b0, "R6");
        rd(2'd0, "R6");
        chk_irq(1'b1, "R6");

        // R5 event in the same cycle as the status read
        cyc(1'b1, 8'h40, 1'b1, 2'd0, "R5");
        chk_irq(1'b0, "R5");
        rd(2'd0, "R5");

        // R7 event in the same cycle as the upper-byte read
        rd(2'd1, "R7"); rd(2'd2, "R8");
        for (int i = 0; i < 3; i++) cyc(1'b1, 8'h40, 1'b0, 2'd0, "R2");
        cyc(1'b1, 8'h40, 1'b1, 2'd1, "R7");
        rd(2'd2, "R8");
        rd(2'd1, "R7"); rd(2'd2, "R7");

        // R2 count above one byte
        for (int i = 0; i < 300; i++) cyc(1'b1, 8'h40, 1'b0, 2'd0, "R2");
        rd(2'd1, "R2"); rd(2'd2, "R2");

        // R3 saturation
        for (int i = 0; i < 65540; i++) cyc(1'b1, 8'h40, 1'b0, 2'd0, "R3");
        rd(2'd1, "R3"); rd(2'd2, "R3");
        rd(2'd1, "R7"); rd(2'd2, "R8");
        rd(2'd0, "R4");

        repeat (2) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 %0d reads never answered, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule